// File: doc/BRIEF.md
# Debug Mailbox with Cross-Domain Handshake

This block moves 32-bit words between an external debugger, which works on the test clock, and the processor core, which works on its own clock. One word slot carries traffic toward the core and a second slot carries traffic toward the debugger. Each slot has a full flag, and each side reads that flag before it moves data. The flag is set when a word is put into the slot and cleared when the far side takes it.

The debugger side sees a small register space. It applies an address, a direction bit and a one-cycle access strobe. The scan framing that produces these is outside the block. Address 4 is the control register and address 5 is the data register. Reading the data register removes a word from the slot toward the debugger, so software uses the control address as the safe idle address. The control register also reports a 4-bit module revision in its top bits.

The core side has a select line that picks the status word or the data word, with read and write strobes. Each full flag reaches the other clock domain as a toggle that passes through a synchroniser chain, so a word only ever changes on the side that owns it.

Top module: `dbg_mailbox`

## Requirements
- R1: A debugger read of address 4 returns the revision parameter (default 6) in bits 31:28, zero in bits 27:2, the toward-debugger full flag in bit 1 and the toward-core full flag in bit 0.
- R2: A debugger access with direction 1 to address 5 loads the toward-core word and sets control bit 0. Core status bit 1 follows within 3 core clocks.
- R3: A core data read (select 1) while core status bit 1 is set returns the word and clears that bit on the next core clock. Debugger control bit 0 clears a few test clocks later.
- R4: A core data write sets core status bit 0 on the next core clock. Debugger control bit 1 becomes set within 3 test clocks.
- R5: A debugger read of address 5 returns the toward-debugger word. If control bit 1 is set, that bit clears on the next test clock and core status bit 0 clears later.
- R6: Reading the control register has no side effect on either flag.
- R7: Writing into a slot that its writer sees as full replaces the word and keeps the flag set. A single read by the far side then empties the slot.
- R8: A data read on either side while its slot is empty returns the last word held and changes no flag.
- R9: A core status read returns bit 0 = outgoing slot still full and bit 1 = incoming word ready, with bits 31:2 zero.
- R10: Each flag crosses between clock domains through a chain of SYNC_STAGES flip-flops (at least 2).
- R11: After reset both flags are clear and both words read as zero.
- R12: Debugger writes to any address other than 5 are ignored. Debugger reads of any address other than 4 or 5 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tck | input | 1 | Debugger-side clock |
| scan_access | input | 1 | One-cycle register access strobe |
| scan_write | input | 1 | Access direction, 1 = write |
| scan_addr | input | 5 | Register address |
| scan_wdata | input | 32 | Write word |
| scan_rdata | output | 32 | Read value of the addressed register |
| clk | input | 1 | Core clock |
| core_sel | input | 1 | 0 = status word, 1 = data word |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | 32 | Core write word |
| core_rdata | output | 32 | Core read value |

## Verification
The hardest case to reach is an overwrite. To set it up, a second write must land while the writer still sees the slot as full, and the far side must not have read the first word yet. The stimulus issues two debugger data writes back to back, then waits for both toggles to settle before the core reads once. It then checks that the core gets the second word and that a second core read finds the slot empty. The same pattern runs in the other direction. The consuming read is also compared with repeated control reads, to show that only the data address drains a slot.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
   localparam int ADDR_W    = 5;
   localparam int VER_W     = 4;
   localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'd4;
   localparam logic [ADDR_W-1:0] ADDR_DATA = 5'd5;
   // control/status flag bit positions
   localparam int BIT_TO_CORE = 0;
   localparam int BIT_TO_HOST = 1;
endpackage

// File: rtl/dbg_flag_sync.sv
module dbg_flag_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("dbg_flag_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbg_slot.sv
// One-word slot: the producer owns the word and a put toggle; the consumer owns a get toggle.
module dbg_slot #(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              clk_p,
   input  logic              put,
   input  logic [DATA_W-1:0] put_data,
   output logic              full_p,
   input  logic              clk_c,
   input  logic              take,
   output logic              full_c,
   output logic [DATA_W-1:0] word
);
   logic put_t, get_t, put_t_c, get_t_p;

   dbg_flag_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
      .clk(clk_c), .rst_n(rst_n), .d(put_t), .q(put_t_c));
   dbg_flag_sync #(.STAGES(SYNC_STAGES)) u_get_sync (
      .clk(clk_p), .rst_n(rst_n), .d(get_t), .q(get_t_p));

   assign full_p = put_t ^ get_t_p;
   assign full_c = put_t_c ^ get_t;

   always_ff @(posedge clk_p or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         put_t <= 1'b0;
      end else if (put) begin
         word <= put_data;
         if (!full_p) put_t <= ~put_t;
      end
   end

   always_ff @(posedge clk_c or negedge rst_n) begin
      if (!rst_n)               get_t <= 1'b0;
      else if (take && full_c)  get_t <= ~get_t;
   end

   AST_TAKE_EMPTIES: assert property (@(posedge clk_c) disable iff (!rst_n)
      (take && full_c) |=> !full_c); // R3
   AST_PUT_FILLS: assert property (@(posedge clk_p) disable iff (!rst_n)
      put |=> full_p); // R7
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
   import dbg_mailbox_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  VERSION     = 4'd6
) (
   input  logic              rst_n,
   input  logic              tck,
   input  logic              scan_access,
   input  logic              scan_write,
   input  logic [ADDR_W-1:0] scan_addr,
   input  logic [DATA_W-1:0] scan_wdata,
   output logic [DATA_W-1:0] scan_rdata,
   input  logic              clk,
   input  logic              core_sel,
   input  logic              core_rd,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata
);
   localparam int PAD_W = DATA_W - VER_W - 2;

   generate
      if (DATA_W < VER_W + 2) begin : g_bad_w
         $error("dbg_mailbox: DATA_W too small for control layout");
      end
   endgenerate

   logic              host_put, host_take;
   logic              to_core_full_h, to_core_full_c;
   logic              to_host_full_c, to_host_full_h;
   logic [DATA_W-1:0] to_core_word, to_host_word;
   logic [DATA_W-1:0] ctrl_word;

   assign host_put  = scan_access &&  scan_write && (scan_addr == ADDR_DATA);
   assign host_take = scan_access && !scan_write && (scan_addr == ADDR_DATA);

   dbg_slot #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_to_core (
      .rst_n(rst_n),
      .clk_p(tck), .put(host_put), .put_data(scan_wdata), .full_p(to_core_full_h),
      .clk_c(clk), .take(core_rd && core_sel), .full_c(to_core_full_c),
      .word(to_core_word));

   dbg_slot #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_to_host (
      .rst_n(rst_n),
      .clk_p(clk), .put(core_wr && core_sel), .put_data(core_wdata), .full_p(to_host_full_c),
      .clk_c(tck), .take(host_take), .full_c(to_host_full_h),
      .word(to_host_word));

   always_comb begin
      ctrl_word = {VERSION, {PAD_W{1'b0}}, 2'b00};
      ctrl_word[BIT_TO_CORE] = to_core_full_h;
      ctrl_word[BIT_TO_HOST] = to_host_full_h;
   end

   always_comb begin
      unique case (scan_addr)
         ADDR_CTRL: scan_rdata = ctrl_word;
         ADDR_DATA: scan_rdata = to_host_word;
         default:   scan_rdata = '0;
      endcase
   end

   // core status: bit0 outgoing busy, bit1 incoming ready
   always_comb begin
      if (core_sel) core_rdata = to_core_word;
      else          core_rdata = {{(DATA_W-2){1'b0}}, to_core_full_c, to_host_full_c};
   end

   AST_CTRL_PAD_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
      (scan_addr == ADDR_CTRL) |-> (scan_rdata[DATA_W-VER_W-1:2] == '0
                                    && scan_rdata[DATA_W-1 -: VER_W] == VERSION)); // R1
   AST_HOST_WRITE_SETS: assert property (@(posedge tck) disable iff (!rst_n)
      host_put |=> scan_rdata[BIT_TO_CORE] || scan_addr != ADDR_CTRL); // R2
   AST_HOST_READ_DRAINS: assert property (@(posedge tck) disable iff (!rst_n)
      (host_take && to_host_full_h) |=> !to_host_full_h); // R5
   AST_CORE_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr && core_sel) |=> to_host_full_c); // R4
   AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !core_sel |-> core_rdata[DATA_W-1:2] == '0); // R9
   AST_CORE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rd && core_sel && to_core_full_c) |=> !to_core_full_c); // R3
endmodule

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;
   logic        rst_n = 1'b0;
   logic        tck = 1'b0;
   logic        clk = 1'b0;
   logic        scan_access = 0, scan_write = 0;
   logic [4:0]  scan_addr = 5'd4;
   logic [31:0] scan_wdata = '0, scan_rdata;
   logic        core_sel = 0, core_rd = 0, core_wr = 0;
   logic [31:0] core_wdata = '0, core_rdata;
   int          total = 0, bad = 0;
   bit          finished = 0;

   always #10 clk = ~clk;   // 50 MHz core clock
   always #35 tck = ~tck;

   dbg_mailbox u0 (.*);

   localparam logic [63:0] VEC [4] = '{
      {32'hDEADBEEF, 32'h12345678},
      {32'h00000001, 32'h80000000},
      {32'hFFFFFFFF, 32'h00000000},
      {32'hA5A55A5A, 32'hC0FFEE11}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge tck);
      @(negedge clk);
   endtask

   task automatic host_rd(input logic [4:0] a, output logic [31:0] v);
      @(negedge tck);
      scan_addr = a; scan_write = 0; scan_access = 1;
      #1 v = scan_rdata;
      @(negedge tck);
      scan_access = 0; scan_addr = 5'd4;
   endtask

   task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge tck);
      scan_addr = a; scan_write = 1; scan_wdata = d; scan_access = 1;
      @(negedge tck);
      scan_access = 0; scan_write = 0; scan_addr = 5'd4;
   endtask

   task automatic core_read(input logic sel, output logic [31:0] v);
      @(negedge clk);
      core_sel = sel; core_rd = 1;
      #1 v = core_rdata;
      @(negedge clk);
      core_rd = 0; core_sel = 0;
   endtask

   task automatic core_write(input logic [31:0] d);
      @(negedge clk);
      core_sel = 1; core_wr = 1; core_wdata = d;
      @(negedge clk);
      core_wr = 0; core_sel = 0;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge tck);
      rst_n = 1'b1;
      settle();
      // R11 / R1 reset state
      host_rd(5'd4, v); check("R1 R11 ctrl after reset", v, 32'h6000_0000);
      host_rd(5'd5, v); check("R11 host data after reset", v, 32'h0);
      core_read(0, v);  check("R11 R9 core status after reset", v, 32'h0);
      core_read(1, v);  check("R11 core data after reset", v, 32'h0);
      core_read(0, v);  check("R8 empty core read no flag", v, 32'h0);

      // table walk: both directions
      for (int i = 0; i < 4; i++) begin
         host_wr(5'd5, VEC[i][63:32]);
         settle();
         host_rd(5'd4, v); check("R2 ctrl bit0 set", v, 32'h6000_0001);
         core_read(0, v);  check("R2 R9 core rx ready", v, 32'h2);
         core_read(1, v);  check("R3 core data", v, VEC[i][63:32]);
         core_read(0, v);  check("R3 core flag cleared", v, 32'h0);
         settle();
         host_rd(5'd4, v); check("R3 ctrl bit0 cleared", v, 32'h6000_0000);
         core_write(VEC[i][31:0]);
         core_read(0, v);  check("R4 R9 core tx busy", v, 32'h1);
         settle();
         host_rd(5'd4, v); check("R4 ctrl bit1 set", v, 32'h6000_0002);
         host_rd(5'd4, v); check("R6 ctrl reread no side effect", v, 32'h6000_0002);
         host_rd(5'd5, v); check("R5 host data", v, VEC[i][31:0]);
         host_rd(5'd4, v); check("R5 ctrl bit1 cleared", v, 32'h6000_0000);
         settle();
         core_read(0, v);  check("R5 core tx busy cleared", v, 32'h0);
      end

      // R8 host data read while empty
      host_rd(5'd5, v); check("R8 empty host read returns last", v, VEC[3][31:0]);
      settle();
      core_read(0, v);  check("R8 empty host read no flag", v, 32'h0);

      // R7 overwrite toward core
      host_wr(5'd5, 32'h1111_1111);
      host_wr(5'd5, 32'h2222_2222);
      settle();
      host_rd(5'd4, v); check("R7 ctrl still full", v, 32'h6000_0001);
      core_read(1, v);  check("R7 core sees newest", v, 32'h2222_2222);
      core_read(0, v);  check("R7 single read empties", v, 32'h0);
      settle();
      host_rd(5'd4, v); check("R7 host sees empty", v, 32'h6000_0000);

      // R7 overwrite toward host
      core_write(32'h3333_3333);
      core_write(32'h4444_4444);
      settle();
      host_rd(5'd5, v); check("R7 host sees newest", v, 32'h4444_4444);
      host_rd(5'd4, v); check("R7 host single read empties", v, 32'h6000_0000);
      settle();
      core_read(0, v);  check("R7 core tx idle", v, 32'h0);

      // R12 ignored writes, zero reads
      host_wr(5'd4, 32'hFFFF_FFFF);
      host_wr(5'd9, 32'hFFFF_FFFF);
      settle();
      host_rd(5'd4, v); check("R12 ctrl unchanged", v, 32'h6000_0000);
      core_read(0, v);  check("R12 core status unchanged", v, 32'h0);
      host_rd(5'd9, v); check("R12 other addr reads zero", v, 32'h0);
      // R10 crossing latency: flag visible within sync window
      host_wr(5'd5, 32'h5555_0000);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      core_sel = 0; #1;
      check("R10 flag crossed within 3 clocks", core_rdata, 32'h2);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule